// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog counter for a system controller. A 20-bit down-counter, advanced by a prescaled tick derived from the bus clock, runs in two stages. When the first stage runs out, the block pulses an interrupt and reloads the counter with the second-stage value. If software still has not serviced the timer when the second stage runs out, the block pulses a reset request, sets a sticky timeout flag, and stops counting.

Software services the timer by "kicking" it. Both the kick and any change to the two stage preloads are guarded by a two-write key sent to the reload register. A control register enables the timer, selects between watchdog and free-running modes, and can lock the timer on so that software cannot turn it off again.

The register port is a plain single-cycle write strobe and a combinational read mux. The bus wrapper, the interrupt controller and the system reset logic sit outside this block. The sticky flag is cleared only by a separate power-on reset, so it still holds its value after the reset that the watchdog itself requested.

Top module: `twostage_wdt`

## Requirements
- R1: Register addresses are 0 = stage-1 preload, 1 = stage-2 preload, 2 = configuration, 3 = reload, 4 = control, 5 = live count. A write to address 0, 1 or 3 changes state only when it is armed. Arming takes the value 0x80 written to address 3 and then the value 0x86 written to address 3. The armed state is consumed by exactly one such protected write.
- R2: Any write to address 3 breaks the key and leaves the block unarmed when it is neither the expected next key value nor the armed write itself. This includes a wrong second value, a stray value between the two key writes, and 0x86 sent first.
- R3: An armed write to address 3 with bit 8 set is a kick. It loads the counter with the stage-1 preload, clears the prescaler and returns the timer to stage 1.
- R4: On the tick that takes the stage-1 count to zero, irqOut pulses high for one cycle and the counter loads the stage-2 preload. With preload N and a tick period of M clocks, the pulse is seen M*N clocks after the kick edge.
- R5: When the stage-2 count reaches zero, rstReq pulses for one cycle, but only if configuration bit 5 is set. A stage-2 preload of 0 expires on its first tick. The counter then stops at 0 until the next kick or re-enable.
- R6: Bit 9 of address 3 is a sticky timeout flag. It is set at every stage-2 expiry, whether or not the reset request is enabled. It keeps its value through rst_n, and is cleared by porRst_n or by an armed write to address 3 with bit 9 set. A write with bit 9 set and bit 8 clear does not kick.
- R7: In the control register, bit 1 is the enable and bit 0 is the lock. While the lock is set, software writes cannot clear either bit, and readback keeps showing them set. rst_n clears the control register.
- R8: Control bit 2 set selects free-running mode. In this mode each stage-1 expiry pulses irqOut and reloads the stage-1 preload, and the block never raises rstReq or sets the flag. Control bit 2 clear selects watchdog mode.
- R9: Configuration bit 2 clear gives one tick every 2^SLOW_LOG2 clocks. Bit 2 set gives one tick every 2^FAST_LOG2 clocks.
- R10: While enable is clear, the count holds at the stage-1 preload and neither irqOut nor rstReq is raised, kicks included.
- R11: Address 5 reads back the live count. irqKind always reflects configuration bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset for everything except the timeout flag |
| porRst_n | input | 1 | Active-low power-on reset, also clears the timeout flag |
| wrEn | input | 1 | Single-cycle register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Combinational read data |
| irqOut | output | 1 | One-cycle pulse on stage-1 expiry |
| irqKind | output | 2 | Interrupt type taken from configuration bits 1:0 |
| rstReq | output | 1 | One-cycle reset request on stage-2 expiry |

## Verification
The main countdown is exercised from a table of preload pairs. The table covers both tick rates, the reset request enabled and disabled, and a zero stage-2 preload. This separates an off-by-one in either stage, a swapped rate select, an ungated reset request and an unset flag. Directed cases then probe the unlock key:
- no key at all,
- a wrong second value,
- a stray write between the two key values,
- a second write after a single arm.

Further directed cases cover a mid-countdown kick that must push the interrupt out, free-running mode with repeated interrupts, the lock surviving a disable attempt, and the flag outliving rst_n while porRst_n clears it.

// File: rtl/twd_pkg.sv
package twd_pkg;

  localparam logic [2:0] ADDR_PRE1   = 3'd0;
  localparam logic [2:0] ADDR_PRE2   = 3'd1;
  localparam logic [2:0] ADDR_CFG    = 3'd2;
  localparam logic [2:0] ADDR_RELOAD = 3'd3;
  localparam logic [2:0] ADDR_CTRL   = 3'd4;
  localparam logic [2:0] ADDR_COUNT  = 3'd5;

  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlockState_t;

  // control -> datapath
  typedef struct packed {
    logic kick;
    logic enable;
    logic fastRate;
    logic freeMode;
    logic resetEn;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic stage1Exp;
    logic stage2Exp;
  } dpEvents_t;

endpackage

// File: rtl/twd_ctrl.sv
module twd_ctrl
  import twd_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter logic [CNT_W-1:0] PRE1_RST = 20'h003FF,
  parameter logic [CNT_W-1:0] PRE2_RST = 20'h003FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              porRst_n,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  dpEvents_t         events,
  input  logic [CNT_W-1:0]  count,
  output ctrlStrobes_t      strb,
  output logic [CNT_W-1:0]  pre1,
  output logic [CNT_W-1:0]  pre2,
  output logic [1:0]        irqKind,
  output logic              lockBit,
  output logic              timeoutFlag,
  output logic              flagClr,
  output logic              armed,
  output logic              protWr
);

  unlockState_t     ulQ;
  logic [CNT_W-1:0] pre1Q, pre2Q;
  logic             resetEnQ, fastQ;
  logic [1:0]       kindQ;
  logic             lockQ, enQ, freeQ, flagQ;
  logic             reloadWr, protAddr, kick;

  assign reloadWr = wrEn && (wrAddr == ADDR_RELOAD);
  assign armed    = (ulQ == UL_ARMED);
  assign protAddr = (wrAddr == ADDR_PRE1) || (wrAddr == ADDR_PRE2) ||
                    (wrAddr == ADDR_RELOAD);
  assign protWr   = wrEn && armed && protAddr;
  assign kick     = protWr && reloadWr && wrData[8];
  assign flagClr  = protWr && reloadWr && wrData[9];

  // unlock key sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ulQ <= UL_IDLE;
    end else if (protWr) begin
      ulQ <= UL_IDLE;
    end else if (reloadWr) begin
      unique case (ulQ)
        UL_IDLE: ulQ <= (wrData[15:0] == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
        UL_HALF: ulQ <= (wrData[15:0] == KEY_SECOND) ? UL_ARMED : UL_IDLE;
        default: ulQ <= UL_IDLE;
      endcase
    end
  end

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1Q    <= PRE1_RST;
      pre2Q    <= PRE2_RST;
      resetEnQ <= 1'b0;
      fastQ    <= 1'b0;
      kindQ    <= 2'd0;
      lockQ    <= 1'b0;
      enQ      <= 1'b0;
      freeQ    <= 1'b0;
    end else if (wrEn) begin
      if (protWr && wrAddr == ADDR_PRE1) pre1Q <= wrData[CNT_W-1:0];
      if (protWr && wrAddr == ADDR_PRE2) pre2Q <= wrData[CNT_W-1:0];
      if (wrAddr == ADDR_CFG) begin
        resetEnQ <= wrData[5];
        fastQ    <= wrData[2];
        kindQ    <= wrData[1:0];
      end
      if (wrAddr == ADDR_CTRL) begin
        if (!lockQ) begin
          freeQ <= wrData[2];
          enQ   <= wrData[1];
          lockQ <= wrData[0];
        end else begin
          enQ <= enQ | wrData[1];
        end
      end
    end
  end

  // sticky timeout flag, only power-on reset clears it
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      flagQ <= 1'b0;
    end else if (events.stage2Exp) begin
      flagQ <= 1'b1;
    end else if (flagClr) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_PRE1:   rdData = DATA_W'(pre1Q);
      ADDR_PRE2:   rdData = DATA_W'(pre2Q);
      ADDR_CFG: begin
        rdData[5]   = resetEnQ;
        rdData[2]   = fastQ;
        rdData[1:0] = kindQ;
      end
      ADDR_RELOAD: rdData[9] = flagQ;
      ADDR_CTRL:   rdData[2:0] = {freeQ, enQ, lockQ};
      ADDR_COUNT:  rdData = DATA_W'(count);
      default:     rdData = '0;
    endcase
  end

  assign strb.kick     = kick;
  assign strb.enable   = enQ;
  assign strb.fastRate = fastQ;
  assign strb.freeMode = freeQ;
  assign strb.resetEn  = resetEnQ;

  assign pre1        = pre1Q;
  assign pre2        = pre2Q;
  assign irqKind     = kindQ;
  assign lockBit     = lockQ;
  assign timeoutFlag = flagQ;

endmodule

// File: rtl/twd_datapath.sv
module twd_datapath
  import twd_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strb,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic [CNT_W-1:0] count,
  output dpEvents_t        events,
  output logic             irqOut,
  output logic             rstReq
);

  localparam logic [SLOW_LOG2-1:0] SLOW_MASK = '1;
  localparam logic [SLOW_LOG2-1:0] FAST_MASK = SLOW_MASK >> (SLOW_LOG2 - FAST_LOG2);

  logic [SLOW_LOG2-1:0] preQ;
  logic [CNT_W-1:0]     countQ;
  logic                 stage2Q, stoppedQ, irqQ, rstQ;
  logic [SLOW_LOG2-1:0] mask;
  logic                 running, tick, lastTick;

  assign mask     = strb.fastRate ? FAST_MASK : SLOW_MASK;
  assign running  = strb.enable && !strb.kick && !stoppedQ;
  assign tick     = running && ((preQ & mask) == mask);
  assign lastTick = tick && (countQ <= CNT_W'(1));

  assign events.stage1Exp = lastTick && (!stage2Q || strb.freeMode);
  assign events.stage2Exp = lastTick && stage2Q && !strb.freeMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preQ     <= '0;
      countQ   <= '0;
      stage2Q  <= 1'b0;
      stoppedQ <= 1'b0;
      irqQ     <= 1'b0;
      rstQ     <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      rstQ <= 1'b0;
      if (!strb.enable || strb.kick) begin
        preQ     <= '0;
        countQ   <= pre1;
        stage2Q  <= 1'b0;
        stoppedQ <= 1'b0;
      end else if (!stoppedQ) begin
        preQ <= preQ + 1'b1;
        if (events.stage1Exp) begin
          irqQ    <= 1'b1;
          countQ  <= strb.freeMode ? pre1 : pre2;
          stage2Q <= !strb.freeMode;
        end else if (events.stage2Exp) begin
          rstQ     <= strb.resetEn;
          stoppedQ <= 1'b1;
          countQ   <= '0;
        end else if (tick) begin
          countQ <= countQ - CNT_W'(1);
        end
      end
    end
  end

  assign count  = countQ;
  assign irqOut = irqQ;
  assign rstReq = rstQ;

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twd_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int DATA_W    = 32,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5,
  parameter logic [CNT_W-1:0] PRE1_RST = 20'h003FF,
  parameter logic [CNT_W-1:0] PRE2_RST = 20'h003FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              porRst_n,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [1:0]        irqKind,
  output logic              rstReq
);

  ctrlStrobes_t     strb;
  dpEvents_t        events;
  logic [CNT_W-1:0] pre1, pre2, count;
  logic             lockBit, timeoutFlag, flagClr, armed, protWr;
  logic             enBit, resetEnBit;

  assign enBit      = strb.enable;
  assign resetEnBit = strb.resetEn;

  twd_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .PRE1_RST(PRE1_RST), .PRE2_RST(PRE2_RST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .porRst_n(porRst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .events(events), .count(count),
    .strb(strb), .pre1(pre1), .pre2(pre2), .irqKind(irqKind),
    .lockBit(lockBit), .timeoutFlag(timeoutFlag), .flagClr(flagClr),
    .armed(armed), .protWr(protWr)
  );

  twd_datapath #(
    .CNT_W(CNT_W), .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pre1(pre1), .pre2(pre2),
    .count(count), .events(events), .irqOut(irqOut), .rstReq(rstReq)
  );

endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk (
  input logic clk,
  input logic rst_n,
  input logic porRst_n,
  input logic irqOut,
  input logic rstReq,
  input logic enBit,
  input logic resetEnBit,
  input logic lockBit,
  input logic timeoutFlag,
  input logic flagClr,
  input logic armed,
  input logic protWr
);

  p_armed_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && protWr) |=> !armed);

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |=> !irqOut);

  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |=> !rstReq);

  p_rst_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstReq) |-> $past(resetEnBit));

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!porRst_n || !rst_n)
    $fell(timeoutFlag) |-> $past(flagClr));

  p_lock_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lockBit |=> lockBit);

  p_lock_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockBit && enBit) |=> enBit);

  p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enBit |=> (!irqOut && !rstReq));

endmodule

bind twostage_wdt twostage_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .porRst_n(porRst_n),
  .irqOut(irqOut), .rstReq(rstReq),
  .enBit(enBit), .resetEnBit(resetEnBit), .lockBit(lockBit),
  .timeoutFlag(timeoutFlag), .flagClr(flagClr),
  .armed(armed), .protWr(protWr)
);

// File: tb/twostage_wdt_test.sv
`timescale 1ns/1ps
module twostage_wdt_test;

  localparam int SLOW = 4;
  localparam int FAST = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, porRst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, rstReq;
  logic [1:0]  irqKind;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  twostage_wdt #(
    .SLOW_LOG2(SLOW), .FAST_LOG2(FAST),
    .PRE1_RST(20'h00010), .PRE2_RST(20'h00008)
  ) uut (
    .clk(clk), .rst_n(rst_n), .porRst_n(porRst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .irqOut(irqOut), .irqKind(irqKind), .rstReq(rstReq)
  );

  typedef struct packed {
    logic        fast;
    logic        rstEn;
    logic [7:0]  pl1;
    logic [7:0]  pl2;
    logic [15:0] expIrq;
    logic [15:0] expEnd;
  } vec_t;

  // expIrq = M*pl1, expEnd = M*(pl1 + max(pl2,1)); M = 4 fast, 16 slow
  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 8'd3, 8'd2, 16'd12, 16'd20},
    '{1'b0, 1'b1, 8'd2, 8'd1, 16'd32, 16'd48},
    '{1'b1, 1'b0, 8'd1, 8'd4, 16'd4,  16'd20},
    '{1'b1, 1'b1, 8'd5, 8'd0, 16'd20, 16'd24}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic unlock();
    wr(3'd3, 32'h80);
    wr(3'd3, 32'h86);
  endtask

  task automatic observe(input int cycles, output int firstIrq, output int irqCnt,
                         output int firstRst, output int rstCnt, output int firstFlag);
    firstIrq = 0; irqCnt = 0; firstRst = 0; rstCnt = 0; firstFlag = 0;
    for (int n = 1; n <= cycles; n++) begin
      @(negedge clk);
      rdAddr = 3'd3;
      #0.5;
      if (irqOut) begin irqCnt++; if (firstIrq == 0) firstIrq = n; end
      if (rstReq) begin rstCnt++; if (firstRst == 0) firstRst = n; end
      if (rdData[9] && firstFlag == 0) firstFlag = n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int fi, ic, fr, rc, ff;

    repeat (3) @(negedge clk);
    rst_n = 1'b1; porRst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R7 reset ctrl", {31'd0, irqOut}, 32'd0);
    chk("R5 reset rstReq", {31'd0, rstReq}, 32'd0);
    rd(3'd4, v); chk("R7 reset ctrl reg", v, 32'd0);
    rd(3'd3, v); chk("R6 reset flag", v, 32'd0);
    rd(3'd5, v); chk("R11 reset count holds pre1", v, 32'h10);
    rd(3'd2, v); chk("R11 reset cfg", v, 32'd0);

    // R1: protected writes
    @(negedge clk);
    wr(3'd0, 32'h7);
    rd(3'd0, v); chk("R1 unarmed preload write ignored", v, 32'h10);
    unlock(); wr(3'd0, 32'h7);
    rd(3'd0, v); chk("R1 armed preload write", v, 32'h7);
    wr(3'd0, 32'h9);
    rd(3'd0, v); chk("R1 arm used by one write", v, 32'h7);

    // R2: broken keys
    @(negedge clk);
    wr(3'd3, 32'h80); wr(3'd3, 32'h85); wr(3'd3, 32'h86); wr(3'd0, 32'h20);
    rd(3'd0, v); chk("R2 wrong second key", v, 32'h7);
    wr(3'd3, 32'h80); wr(3'd3, 32'h12); wr(3'd3, 32'h86); wr(3'd1, 32'h5);
    rd(3'd1, v); chk("R2 stray write between keys", v, 32'h8);
    unlock(); wr(3'd1, 32'h5);
    rd(3'd1, v); chk("R1 armed stage2 preload", v, 32'h5);

    // R10: disabled timer
    @(negedge clk);
    unlock(); wr(3'd3, 32'h100);
    observe(100, fi, ic, fr, rc, ff);
    chk("R10 no irq while disabled", ic, 0);
    chk("R10 no rst while disabled", rc, 0);
    rd(3'd5, v); chk("R10 count holds pre1", v, 32'h7);

    // table-driven countdowns
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr(3'd4, 32'h0);
      unlock(); wr(3'd0, {24'd0, VECS[i].pl1});
      unlock(); wr(3'd1, {24'd0, VECS[i].pl2});
      wr(3'd2, {26'd0, VECS[i].rstEn, 2'b00, VECS[i].fast, i[1:0]});
      wr(3'd4, 32'h2);
      unlock(); wr(3'd3, 32'h300);
      observe(int'(VECS[i].expEnd) + 12, fi, ic, fr, rc, ff);
      chk($sformatf("R4 R9 vec%0d irq cycle", i), fi, int'(VECS[i].expIrq));
      chk($sformatf("R4 vec%0d irq count", i), ic, 1);
      chk($sformatf("R5 vec%0d rst cycle", i), fr, VECS[i].rstEn ? int'(VECS[i].expEnd) : 0);
      chk($sformatf("R5 vec%0d rst count", i), rc, VECS[i].rstEn ? 1 : 0);
      chk($sformatf("R6 vec%0d flag cycle", i), ff, int'(VECS[i].expEnd));
      chk($sformatf("R11 vec%0d irqKind", i), {30'd0, irqKind}, i);
      rd(3'd5, v); chk($sformatf("R5 vec%0d stopped at zero", i), v, 32'd0);
    end

    // R5/R3: kick restarts a stopped timer (pl1 = 5, pl2 = 0, fast)
    @(negedge clk);
    unlock(); wr(3'd3, 32'h100);
    rd(3'd5, v); chk("R3 kick reloads pre1", v, 32'h5);
    observe(12, fi, ic, fr, rc, ff);
    chk("R3 no irq before re-kick", ic, 0);
    unlock(); wr(3'd3, 32'h100);
    observe(30, fi, ic, fr, rc, ff);
    chk("R3 mid kick delays irq", fi, 20);

    // R8: free-running mode
    @(negedge clk);
    wr(3'd4, 32'h0);
    unlock(); wr(3'd0, 32'h3);
    wr(3'd4, 32'h6);
    unlock(); wr(3'd3, 32'h300);
    observe(40, fi, ic, fr, rc, ff);
    chk("R8 free first irq", fi, 12);
    chk("R8 free repeated irqs", ic, 3);
    chk("R8 free no rst", rc, 0);
    chk("R8 free no flag", ff, 0);

    // R6: clear by bit 9 alone
    @(negedge clk);
    wr(3'd4, 32'h0);
    unlock(); wr(3'd0, 32'h1);
    unlock(); wr(3'd1, 32'h1);
    wr(3'd2, 32'h24);
    wr(3'd4, 32'h2);
    unlock(); wr(3'd3, 32'h300);
    observe(12, fi, ic, fr, rc, ff);
    rd(3'd3, v); chk("R6 flag set", v, 32'h200);
    @(negedge clk);
    unlock(); wr(3'd3, 32'h200);
    rd(3'd3, v); chk("R6 flag cleared by bit9", v, 32'h0);
    rd(3'd5, v); chk("R6 bit9 alone no kick", v, 32'h0);
    @(negedge clk);
    unlock(); wr(3'd3, 32'h100);
    observe(12, fi, ic, fr, rc, ff);

    // R7: lock
    @(negedge clk);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R7 unlocked disable", v, 32'h0);
    wr(3'd4, 32'h3);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R7 locked disable refused", v & 32'h7, 32'h3);

    // R6: flag survives rst_n, porRst_n clears it
    @(negedge clk);
    unlock(); wr(3'd3, 32'h100);
    observe(12, fi, ic, fr, rc, ff);
    rd(3'd3, v); chk("R6 flag before rst_n", v, 32'h200);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, v); chk("R6 flag survives rst_n", v, 32'h200);
    rd(3'd4, v); chk("R7 rst_n clears lock", v, 32'h0);
    @(negedge clk);
    porRst_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    porRst_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, v); chk("R6 porRst_n clears flag", v, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule